// File: doc/BRIEF.md
# Exception State Register File

This block keeps the exception state of a 32-bit processor core in four software-visible registers: a fault-address register, a status register, a cause register and a return-PC register. The control unit pulses an exception strobe with a 4-bit reason code and its already-incremented PC. It may also present the memory address that faulted. On that strobe the block records everything the handler needs in one clock edge, and it drops the core into kernel mode with interrupts disabled.

The status register holds an 8-level interrupt mask and a three-deep stack of (user-mode, interrupt-enable) pairs. An exception pushes the stack and a restore strobe pops it. Five hardware interrupt lines feed sticky pending bits in the cause register, and an acknowledge vector clears them. The block raises an interrupt request whenever an unmasked pending level exists and the current enable bit is set. Software reads and writes the registers through a single port addressed by register number: fault address 8, status 12, cause 13, return PC 14.

Top module: `exc_state_regs`

## Requirements
- R1: After reset every register reads 0 and `irq_req_o` is 0.
- R2: Register 12 (status) stores written bits 15:8 (mask; bits 12:8 gate hardware levels 0..4, bits 15:13 are software levels) and bits 5:0 (mode stack: bit 0 current enable, bit 1 current user mode, bits 3:2 previous pair, bits 5:4 oldest pair). All other bits read 0.
- R3: On `exc_valid_i`, status bits 5:0 become {old bits 3:0, 2'b00}. The mask is unaffected by the exception. When a status write coincides with an exception, the push wins for bits 5:0 and the write still sets the mask.
- R4: On `exc_valid_i`, cause bits 5:2 take `exc_code_i` (0 interrupt, 4 load/fetch address error, 5 store address error, 6 fetch bus error, 7 data bus error, 8 syscall, 9 breakpoint, 10 reserved instruction, 12 overflow). Port writes to register 13 have no effect.
- R5: On `exc_valid_i`, register 14 takes `exc_pc_next_i - 4`. Register 14 can also be written through the port.
- R6: Register 8 loads `exc_badaddr_i` only when `exc_valid_i` and `exc_badaddr_valid_i` are both high. Otherwise, including on port writes, it holds its value.
- R7: Cause bit 8+i is set the cycle after `irq_i[i]` is high and stays set until `irq_ack_i[i]` is high while `irq_i[i]` is low. A high line beats an acknowledge.
- R8: `irq_req_o` is 1 exactly when some cause bit 8+i and status bit 8+i are both 1 and status bit 0 is 1.
- R9: On `rfe_i` without `exc_valid_i`, status bits 3:0 take old bits 5:2 and bits 5:4 are kept. If both strobes are high, the exception push applies.
- R10: Reads of any register number other than 8, 12, 13 and 14 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exc_valid_i | input | 1 | Exception entry strobe |
| exc_code_i | input | 4 | Exception reason code |
| exc_pc_next_i | input | 32 | Incremented PC of the faulting instruction |
| exc_badaddr_valid_i | input | 1 | Fault address present with this exception |
| exc_badaddr_i | input | 32 | Faulting memory address |
| rfe_i | input | 1 | Restore strobe, pops the mode stack |
| irq_i | input | 5 | Hardware interrupt lines, level |
| irq_ack_i | input | 5 | Per-level pending clear |
| reg_we_i | input | 1 | Register write enable |
| reg_waddr_i | input | 5 | Write register number |
| reg_wdata_i | input | 32 | Write data |
| reg_raddr_i | input | 5 | Read register number |
| reg_rdata_o | output | 32 | Read data, combinational |
| irq_req_o | output | 1 | Interrupt request to the core |

## Verification
Every strobe, write and interrupt line is captured at one clock edge, so its effect is due in the register contents one cycle later. Read data and the interrupt request follow the registers combinationally, so they are valid in that same cycle after the edge. The bench drives inputs on the falling edge, lets exactly one rising edge pass, and removes the strobes. It then sets the read address and samples a nanosecond later, before the next rising edge. Sticky and priority cases run each stimulus for one edge only and read back in the next low phase, so a check cannot see a later edge.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int unsigned XLEN       = 32;
  localparam int unsigned REG_AW     = 5;
  localparam int unsigned NUM_HW_IRQ = 5;
  localparam int unsigned CODE_W     = 4;
  localparam int unsigned MODE_W     = 6;
  localparam int unsigned MASK_W     = 8;

  // register numbers seen by software
  localparam logic [REG_AW-1:0] REG_BADADDR = REG_AW'(8);
  localparam logic [REG_AW-1:0] REG_STATUS  = REG_AW'(12);
  localparam logic [REG_AW-1:0] REG_CAUSE   = REG_AW'(13);
  localparam logic [REG_AW-1:0] REG_RETPC   = REG_AW'(14);

  // field positions
  localparam int unsigned MASK_LSB = 8;
  localparam int unsigned PEND_LSB = 8;
  localparam int unsigned CODE_LSB = 2;

  typedef enum logic [CODE_W-1:0] {
    EXC_INT      = 4'd0,
    EXC_ADDR_LD  = 4'd4,
    EXC_ADDR_ST  = 4'd5,
    EXC_BUS_FETCH= 4'd6,
    EXC_BUS_DATA = 4'd7,
    EXC_SYSCALL  = 4'd8,
    EXC_BREAK    = 4'd9,
    EXC_RSVD_OP  = 4'd10,
    EXC_OVERFLOW = 4'd12
  } exc_code_e;
endpackage

// File: rtl/exc_status_reg.sv
module exc_status_reg #(
  parameter int unsigned MODE_W = 6,
  parameter int unsigned MASK_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exc_i,
  input  logic              rfe_i,
  input  logic              we_i,
  input  logic [MASK_W-1:0] wmask_i,
  input  logic [MODE_W-1:0] wmode_i,
  output logic [MASK_W-1:0] mask_o,
  output logic [MODE_W-1:0] mode_o
);
  logic [MASK_W-1:0] mask_q;
  logic [MODE_W-1:0] mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else if (we_i) mask_q <= wmask_i;
  end

  // push beats pop beats write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mode_q <= '0;
    else if (exc_i) mode_q <= {mode_q[MODE_W-3:0], 2'b00};
    else if (rfe_i) mode_q <= {mode_q[MODE_W-1:MODE_W-2], mode_q[MODE_W-1:2]};
    else if (we_i)  mode_q <= wmode_i;
  end

  assign mask_o = mask_q;
  assign mode_o = mode_q;

  a_r3_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_i |=> mode_q == {$past(mode_q[MODE_W-3:0]), 2'b00});
  a_r3_mask_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mask_q));
  a_r9_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfe_i && !exc_i) |=> mode_q[MODE_W-1:MODE_W-2] == $past(mode_q[MODE_W-1:MODE_W-2])
                          && mode_q[MODE_W-3:0] == $past(mode_q[MODE_W-1:2]));
endmodule

// File: rtl/exc_cause_reg.sv
module exc_cause_reg #(
  parameter int unsigned NUM_HW_IRQ = 5,
  parameter int unsigned CODE_W     = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  exc_i,
  input  logic [CODE_W-1:0]     code_i,
  input  logic [NUM_HW_IRQ-1:0] irq_i,
  input  logic [NUM_HW_IRQ-1:0] ack_i,
  output logic [CODE_W-1:0]     code_o,
  output logic [NUM_HW_IRQ-1:0] pend_o
);
  logic [CODE_W-1:0]     code_q;
  logic [NUM_HW_IRQ-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    code_q <= '0;
    else if (exc_i) code_q <= code_i;
  end

  for (genvar i = 0; i < NUM_HW_IRQ; i++) begin : g_pend
    // a live line wins over an acknowledge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       pend_q[i] <= 1'b0;
      else if (irq_i[i]) pend_q[i] <= 1'b1;
      else if (ack_i[i]) pend_q[i] <= 1'b0;
    end

    a_r7_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_i[i] |=> pend_q[i]);
    a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_q[i] && !ack_i[i]) |=> pend_q[i]);
  end

  assign code_o = code_q;
  assign pend_o = pend_q;

  a_r4_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_i |=> code_q == $past(code_i));
  a_r4_code_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_i |=> $stable(code_q));
endmodule

// File: rtl/exc_addr_regs.sv
module exc_addr_regs #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            exc_i,
  input  logic [XLEN-1:0] pc_next_i,
  input  logic            bad_valid_i,
  input  logic [XLEN-1:0] bad_addr_i,
  input  logic            retpc_we_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] retpc_o,
  output logic [XLEN-1:0] bad_o
);
  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

  logic [XLEN-1:0] retpc_q, bad_q;

  // undo the fetch increment so the handler sees the faulting instruction
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         retpc_q <= '0;
    else if (exc_i)      retpc_q <= pc_next_i - INSN_BYTES;
    else if (retpc_we_i) retpc_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   bad_q <= '0;
    else if (exc_i && bad_valid_i) bad_q <= bad_addr_i;
  end

  assign retpc_o = retpc_q;
  assign bad_o   = bad_q;

  a_r5_retpc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_i |=> retpc_q + INSN_BYTES == $past(pc_next_i));
  a_r6_bad_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(exc_i && bad_valid_i) |=> $stable(bad_q));
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
  import exc_pkg::*;
#(
  parameter int unsigned XLEN_P   = XLEN,
  parameter int unsigned REG_AW_P = REG_AW,
  parameter int unsigned HW_IRQ_P = NUM_HW_IRQ
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                exc_valid_i,
  input  logic [CODE_W-1:0]   exc_code_i,
  input  logic [XLEN_P-1:0]   exc_pc_next_i,
  input  logic                exc_badaddr_valid_i,
  input  logic [XLEN_P-1:0]   exc_badaddr_i,
  input  logic                rfe_i,
  input  logic [HW_IRQ_P-1:0] irq_i,
  input  logic [HW_IRQ_P-1:0] irq_ack_i,
  input  logic                reg_we_i,
  input  logic [REG_AW_P-1:0] reg_waddr_i,
  input  logic [XLEN_P-1:0]   reg_wdata_i,
  input  logic [REG_AW_P-1:0] reg_raddr_i,
  output logic [XLEN_P-1:0]   reg_rdata_o,
  output logic                irq_req_o
);
  logic [MASK_W-1:0]   mask;
  logic [MODE_W-1:0]   mode;
  logic [CODE_W-1:0]   code;
  logic [HW_IRQ_P-1:0] pend;
  logic [XLEN_P-1:0]   retpc, bad;
  logic                status_we, retpc_we;

  assign status_we = reg_we_i && (reg_waddr_i == REG_AW_P'(REG_STATUS));
  assign retpc_we  = reg_we_i && (reg_waddr_i == REG_AW_P'(REG_RETPC));

  exc_status_reg #(.MODE_W(MODE_W), .MASK_W(MASK_W)) u_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .exc_i   (exc_valid_i),
    .rfe_i   (rfe_i),
    .we_i    (status_we),
    .wmask_i (reg_wdata_i[MASK_LSB +: MASK_W]),
    .wmode_i (reg_wdata_i[MODE_W-1:0]),
    .mask_o  (mask),
    .mode_o  (mode)
  );

  exc_cause_reg #(.NUM_HW_IRQ(HW_IRQ_P), .CODE_W(CODE_W)) u_cause (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .exc_i  (exc_valid_i),
    .code_i (exc_code_i),
    .irq_i  (irq_i),
    .ack_i  (irq_ack_i),
    .code_o (code),
    .pend_o (pend)
  );

  exc_addr_regs #(.XLEN(XLEN_P)) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .exc_i       (exc_valid_i),
    .pc_next_i   (exc_pc_next_i),
    .bad_valid_i (exc_badaddr_valid_i),
    .bad_addr_i  (exc_badaddr_i),
    .retpc_we_i  (retpc_we),
    .wdata_i     (reg_wdata_i),
    .retpc_o     (retpc),
    .bad_o       (bad)
  );

  // hardware levels occupy the low end of the mask field
  assign irq_req_o = mode[0] && |(pend & mask[HW_IRQ_P-1:0]);

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_raddr_i)
      REG_AW_P'(REG_BADADDR): reg_rdata_o = bad;
      REG_AW_P'(REG_RETPC):   reg_rdata_o = retpc;
      REG_AW_P'(REG_STATUS): begin
        reg_rdata_o[MASK_LSB +: MASK_W] = mask;
        reg_rdata_o[MODE_W-1:0]         = mode;
      end
      REG_AW_P'(REG_CAUSE): begin
        reg_rdata_o[PEND_LSB +: HW_IRQ_P] = pend;
        reg_rdata_o[CODE_LSB +: CODE_W]   = code;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  a_r8_no_req_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode[0] |-> !irq_req_o);
  a_r8_no_req_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend == '0) |-> !irq_req_o);
  a_r3_entry_kernel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_i |=> !irq_req_o);
endmodule

// File: tb/sim_exc_state_regs.sv
module sim_exc_state_regs;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        exc_valid = 0, bad_valid = 0, rfe = 0, we = 0;
  logic [3:0]  code = '0;
  logic [31:0] pc_next = '0, bad_addr = '0, wdata = '0, rdata;
  logic [4:0]  irq = '0, ack = '0, waddr = '0, raddr = '0;
  logic        irq_req;
  int          checks = 0, failures = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  exc_state_regs u0 (
    .clk_i(clk), .rst_ni(rst_ni), .exc_valid_i(exc_valid), .exc_code_i(code),
    .exc_pc_next_i(pc_next), .exc_badaddr_valid_i(bad_valid), .exc_badaddr_i(bad_addr),
    .rfe_i(rfe), .irq_i(irq), .irq_ack_i(ack), .reg_we_i(we), .reg_waddr_i(waddr),
    .reg_wdata_i(wdata), .reg_raddr_i(raddr), .reg_rdata_o(rdata), .irq_req_o(irq_req)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    exc_valid = 0; bad_valid = 0; rfe = 0; we = 0; irq = '0; ack = '0;
  endtask

  task automatic rd_chk(string req, logic [4:0] a, logic [31:0] exp);
    raddr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    we = 1; waddr = a; wdata = d;
    step();
  endtask

  task automatic t_reset();
    rd_chk("R1 badaddr", 5'd8, 0);
    rd_chk("R1 status", 5'd12, 0);
    rd_chk("R1 cause", 5'd13, 0);
    rd_chk("R1 retpc", 5'd14, 0);
    chk("R1 irq_req", {31'b0, irq_req}, 0);
  endtask

  task automatic t_status_rw();
    wr(5'd12, 32'hFFFF_FFFF);
    rd_chk("R2 status unused bits zero", 5'd12, 32'h0000_FF3F);
  endtask

  task automatic t_exception();
    wr(5'd12, 32'h0000_A50D);
    exc_valid = 1; code = 4'd10; pc_next = 32'h0000_1000;
    step();
    rd_chk("R3 push", 5'd12, 32'h0000_A534);
    rd_chk("R4 cause code 10", 5'd13, 32'h0000_0028);
    rd_chk("R5 retpc", 5'd14, 32'h0000_0FFC);
    rd_chk("R6 badaddr untouched", 5'd8, 0);
    // exception with same-cycle status write
    exc_valid = 1; code = 4'd12; pc_next = 32'h0000_2004;
    we = 1; waddr = 5'd12; wdata = 32'h0000_0003;
    step();
    rd_chk("R3 push beats write", 5'd12, 32'h0000_0010);
    rd_chk("R4 cause code 12", 5'd13, 32'h0000_0030);
    rd_chk("R5 retpc second", 5'd14, 32'h0000_2000);
  endtask

  task automatic t_badaddr();
    exc_valid = 1; bad_valid = 1; code = 4'd4; pc_next = 32'h0000_3008;
    bad_addr = 32'hDEAD_BEE0;
    step();
    rd_chk("R6 badaddr load", 5'd8, 32'hDEAD_BEE0);
    wr(5'd8, 32'h0000_1234);
    rd_chk("R6 badaddr write ignored", 5'd8, 32'hDEAD_BEE0);
    wr(5'd13, 32'hFFFF_FFFF);
    rd_chk("R4 cause write ignored", 5'd13, 32'h0000_0010);
    wr(5'd14, 32'h0000_4444);
    rd_chk("R5 retpc write", 5'd14, 32'h0000_4444);
  endtask

  task automatic t_restore();
    wr(5'd12, 32'h0000_0034);
    rfe = 1;
    step();
    rd_chk("R9 pop", 5'd12, 32'h0000_003D);
    rfe = 1; exc_valid = 1; code = 4'd8; pc_next = 32'h0000_5000;
    step();
    rd_chk("R9 exception beats pop", 5'd12, 32'h0000_0034);
  endtask

  task automatic t_irq();
    // cause code is now 8 -> 0x20
    wr(5'd12, 32'h0000_0401);
    chk("R8 no pending", {31'b0, irq_req}, 0);
    irq = 5'b00100;
    step();
    rd_chk("R7 pending level2", 5'd13, 32'h0000_0420);
    chk("R8 req masked-in", {31'b0, irq_req}, 1);
    step();
    rd_chk("R7 sticky after line drop", 5'd13, 32'h0000_0420);
    irq = 5'b01000;
    step();
    rd_chk("R7 pending level3", 5'd13, 32'h0000_0C20);
    ack = 5'b00100;
    step();
    rd_chk("R7 ack clears level2", 5'd13, 32'h0000_0820);
    chk("R8 level3 masked off", {31'b0, irq_req}, 0);
    wr(5'd12, 32'h0000_0800);
    chk("R8 enable low", {31'b0, irq_req}, 0);
    wr(5'd12, 32'h0000_0801);
    chk("R8 enable high", {31'b0, irq_req}, 1);
    irq = 5'b10000; ack = 5'b10000;
    step();
    rd_chk("R7 line beats ack", 5'd13, 32'h0000_1820);
  endtask

  task automatic t_unknown();
    rd_chk("R10 reg0", 5'd0, 0);
    rd_chk("R10 reg3", 5'd3, 0);
    rd_chk("R10 reg31", 5'd31, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_status_rw();
    t_exception();
    t_badaddr();
    t_restore();
    t_irq();
    t_unknown();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule